// File: doc/BRIEF.md
# External PCI Bus Bring-Up Sequencer

This block brings an external PCI bus out of reset when a host bridge starts up. After a start pulse it works through a fixed series of steps, each held for a timed interval. First it turns on the drivers for the bus reset and bus clock pins. Next it starts the bus clock while reset is still asserted. It then releases the active-low bus reset and hands bus arbitration to the internal arbiter. Finally it waits a long settling interval before it allows configuration traffic.

The configuration logic drives `cfg_done` once it has programmed the bridge. The sequencer then waits a last controller settle interval and raises `ready`. Each interval is given in microseconds and converted to clock cycles from the `CLK_HZ` parameter, rounded up, so that no wait is shorter than the time asked for. A synchronous local reset returns every bus control output to its safe state from any step: drivers off, clock off, reset asserted.

Top module: `pci_bus_bringup`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every output is 0: drivers off, clock off, `bus_rst_n` low, arbiter not selected, `cfg_open`, `busy` and `ready` low.
- R2: In the cycle after `start` is sampled high in the idle state, `bus_rst_oe` and `bus_clk_oe` are 1 while `bus_clk_en` and `bus_rst_n` stay 0, and `busy` is 1.
- R3: `bus_clk_en` rises exactly one cycle after the drivers turn on. `bus_rst_n` then stays low for exactly ceil(RST_HOLD_US*CLK_HZ/1e6) cycles with the clock running.
- R4: `arb_internal` rises exactly one cycle after `bus_rst_n` rises.
- R5: `cfg_open` rises exactly ceil(ARB_WAIT_US*CLK_HZ/1e6) + ceil(CFG_SETTLE_US*CLK_HZ/1e6) cycles after `arb_internal` rises.
- R6: `cfg_open` stays high until `cfg_done` is sampled high. It falls in the next cycle, and `ready` rises exactly ceil(READY_US*CLK_HZ/1e6) cycles after that fall. `busy` is high from the driver-enable step until `ready` rises, and `ready` and `busy` are never high together.
- R7: Once `ready` is high, all bus control outputs stay on and a new `start` pulse changes no output.
- R8: Asserting `rst` in the middle of the sequence returns all outputs to the R1 state in the next cycle.
- R9: A `cfg_done` pulse before `cfg_open` is high is ignored. The R5 timing is kept, and `cfg_open` stays high afterwards until a later `cfg_done`.
- R10: The bus clock is never enabled without both drivers on, `bus_rst_n` is never high without the clock enabled, and `cfg_open` is never high without the arbiter selected and the reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high local reset |
| start | input | 1 | Pulse that begins the bring-up sequence from idle |
| cfg_done | input | 1 | Configuration logic reports that the bridge is programmed |
| bus_rst_oe | output | 1 | Output enable of the bus reset driver |
| bus_clk_oe | output | 1 | Output enable of the bus clock driver |
| bus_clk_en | output | 1 | Bus clock running |
| bus_rst_n | output | 1 | Active-low bus reset level (1 = released) |
| arb_internal | output | 1 | Internal bus arbiter selected |
| cfg_open | output | 1 | Configuration traffic allowed |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Bus brought up and controller ready |

## Verification
The bench runs the design with a clock rate of 2.5 cycles per microsecond, so the 1 us wait rounds up from 2.5 to 3 cycles. This separates rounding up from truncation, and it makes each long interval an exact cycle count that the bench compares against. The sequence is run three ways. The first is a full run with a stray `cfg_done` pulse during the settle wait, which shows whether the early pulse is ignored. The second is a run aborted by reset during the reset hold, which shows whether the safe state returns at once. The third is a run with `cfg_done` held high throughout, which shows that the configuration window opens for one cycle only and that the final timing is measured from its close. A start pulse while ready confirms that the finished state cannot be disturbed.

// File: rtl/pci_bringup_pkg.sv
package pci_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DRV    = 3'd1,
    ST_CLKON  = 3'd2,
    ST_REL    = 3'd3,
    ST_ARB    = 3'd4,
    ST_SETTLE = 3'd5,
    ST_OPEN   = 3'd6,
    ST_FINAL  = 3'd7
  } step_t;

  // Converts microseconds to clock cycles, rounded up, never below one.
  function automatic longint us_to_cyc(input longint us, input longint hz);
    longint c;
    c = (us * hz + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bringup_outreg.sv
module bringup_outreg
  import pci_bringup_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_t step_d,
  input  logic  done_d,
  output logic  bus_rst_oe,
  output logic  bus_clk_oe,
  output logic  bus_clk_en,
  output logic  bus_rst_n,
  output logic  arb_internal,
  output logic  cfg_open,
  output logic  busy,
  output logic  ready
);
  logic oe_c, clk_c, rel_c, arb_c, open_c, busy_c;

  always_comb begin
    oe_c   = done_d;
    clk_c  = done_d;
    rel_c  = done_d;
    arb_c  = done_d;
    open_c = 1'b0;
    busy_c = 1'b0;
    if (!done_d) begin
      unique case (step_d)
        ST_IDLE: ;
        ST_DRV: begin
          oe_c = 1'b1; busy_c = 1'b1;
        end
        ST_CLKON: begin
          oe_c = 1'b1; clk_c = 1'b1; busy_c = 1'b1;
        end
        ST_REL: begin
          oe_c = 1'b1; clk_c = 1'b1; rel_c = 1'b1; busy_c = 1'b1;
        end
        ST_ARB, ST_SETTLE, ST_FINAL: begin
          oe_c = 1'b1; clk_c = 1'b1; rel_c = 1'b1; arb_c = 1'b1;
          busy_c = 1'b1;
        end
        ST_OPEN: begin
          oe_c = 1'b1; clk_c = 1'b1; rel_c = 1'b1; arb_c = 1'b1;
          open_c = 1'b1; busy_c = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rst_oe   <= 1'b0;
      bus_clk_oe   <= 1'b0;
      bus_clk_en   <= 1'b0;
      bus_rst_n    <= 1'b0;
      arb_internal <= 1'b0;
      cfg_open     <= 1'b0;
      busy         <= 1'b0;
      ready        <= 1'b0;
    end else begin
      bus_rst_oe   <= oe_c;
      bus_clk_oe   <= oe_c;
      bus_clk_en   <= clk_c;
      bus_rst_n    <= rel_c;
      arb_internal <= arb_c;
      cfg_open     <= open_c;
      busy         <= busy_c;
      ready        <= done_d;
    end
  end
endmodule

// File: rtl/pci_bus_bringup.sv
module pci_bus_bringup
  import pci_bringup_pkg::*;
#(
  parameter longint CLK_HZ        = 100_000_000,
  parameter longint RST_HOLD_US   = 150,
  parameter longint ARB_WAIT_US   = 1,
  parameter longint CFG_SETTLE_US = 1000,
  parameter longint READY_US      = 10_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cfg_done,
  output logic bus_rst_oe,
  output logic bus_clk_oe,
  output logic bus_clk_en,
  output logic bus_rst_n,
  output logic arb_internal,
  output logic cfg_open,
  output logic busy,
  output logic ready
);
  localparam longint HOLD_C   = us_to_cyc(RST_HOLD_US, CLK_HZ);
  localparam longint ARB_C    = us_to_cyc(ARB_WAIT_US, CLK_HZ);
  localparam longint SETTLE_C = us_to_cyc(CFG_SETTLE_US, CLK_HZ);
  localparam longint READY_C  = us_to_cyc(READY_US, CLK_HZ);
  localparam longint MAX_AB   = (HOLD_C > ARB_C) ? HOLD_C : ARB_C;
  localparam longint MAX_CD   = (SETTLE_C > READY_C) ? SETTLE_C : READY_C;
  localparam longint MAX_C    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int     CW       = $clog2(MAX_C + 1);

  step_t         step_q, step_d;
  logic          done_q, done_d;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_val;

  // Next-step logic: a timed step advances when its timer reaches zero.
  always_comb begin
    step_d = step_q;
    done_d = done_q;
    if (!done_q) begin
      unique case (step_q)
        ST_IDLE:   if (start)    step_d = ST_DRV;
        ST_DRV:    if (tmr_exp)  step_d = ST_CLKON;
        ST_CLKON:  if (tmr_exp)  step_d = ST_REL;
        ST_REL:    if (tmr_exp)  step_d = ST_ARB;
        ST_ARB:    if (tmr_exp)  step_d = ST_SETTLE;
        ST_SETTLE: if (tmr_exp)  step_d = ST_OPEN;
        ST_OPEN:   if (cfg_done) step_d = ST_FINAL;
        ST_FINAL:  if (tmr_exp)  done_d = 1'b1;
        default:                 step_d = ST_IDLE;
      endcase
    end
  end

  // A step lasting N cycles loads N-1 on entry.
  always_comb begin
    tmr_load = (step_d != step_q);
    unique case (step_d)
      ST_CLKON:  tmr_val = CW'(HOLD_C - 1);
      ST_ARB:    tmr_val = CW'(ARB_C - 1);
      ST_SETTLE: tmr_val = CW'(SETTLE_C - 1);
      ST_FINAL:  tmr_val = CW'(READY_C - 1);
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  bringup_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  bringup_outreg u_out (
    .clk          (clk),
    .rst          (rst),
    .step_d       (step_d),
    .done_d       (done_d),
    .bus_rst_oe   (bus_rst_oe),
    .bus_clk_oe   (bus_clk_oe),
    .bus_clk_en   (bus_clk_en),
    .bus_rst_n    (bus_rst_n),
    .arb_internal (arb_internal),
    .cfg_open     (cfg_open),
    .busy         (busy),
    .ready        (ready)
  );
endmodule

// File: rtl/pci_bus_bringup_chk.sv
module pci_bus_bringup_chk
  import pci_bringup_pkg::*;
#(
  parameter longint CLK_HZ      = 100_000_000,
  parameter longint RST_HOLD_US = 150
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cfg_done,
  input logic bus_rst_oe,
  input logic bus_clk_oe,
  input logic bus_clk_en,
  input logic bus_rst_n,
  input logic arb_internal,
  input logic cfg_open,
  input logic busy,
  input logic ready
);
  localparam longint HOLD_MIN = us_to_cyc(RST_HOLD_US, CLK_HZ);

  // Cycles spent with the clock running and the bus still in reset.
  logic [31:0] hold_cnt;
  always_ff @(posedge clk) begin
    if (rst || !bus_clk_en)   hold_cnt <= '0;
    else if (!bus_rst_n && hold_cnt != 32'hFFFF_FFFF) hold_cnt <= hold_cnt + 1'b1;
  end

  assert_reset_safe_R8: assert property (@(posedge clk)
    rst |=> (!bus_rst_oe && !bus_clk_oe && !bus_clk_en && !bus_rst_n &&
             !arb_internal && !cfg_open && !busy && !ready));

  assert_clk_needs_drv_R10: assert property (@(posedge clk) disable iff (rst)
    bus_clk_en |-> (bus_clk_oe && bus_rst_oe));

  assert_rel_needs_clk_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rst_n |-> bus_clk_en);

  assert_open_needs_arb_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_open |-> (arb_internal && bus_rst_n));

  assert_hold_time_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rst_n) |-> (longint'(hold_cnt) >= HOLD_MIN));

  assert_arb_after_rel_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_internal) |-> $past(bus_rst_n));

  assert_ready_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !(ready && busy));

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

bind pci_bus_bringup pci_bus_bringup_chk #(
  .CLK_HZ      (CLK_HZ),
  .RST_HOLD_US (RST_HOLD_US)
) u_chk (.*);

// File: tb/test_pci_bus_bringup.sv
module test_pci_bus_bringup;
  localparam int     CLK_PERIOD = 10;
  localparam longint HZ         = 2_500_000;

  function automatic int cyc_of(input longint us);
    return int'((us * HZ + 999_999) / 1_000_000);
  endfunction

  localparam int E_HOLD   = 375;   // 150 us at 2.5 cycles/us
  localparam int E_ARB    = 3;     // 1 us -> 2.5 rounded up
  localparam int E_SETTLE = 2500;
  localparam int E_READY  = 25000;

  logic clk = 0, rst = 1, start = 0, cfg_done = 0;
  logic bus_rst_oe, bus_clk_oe, bus_clk_en, bus_rst_n;
  logic arb_internal, cfg_open, busy, ready;
  int   n_tests = 0, n_fail = 0, cyc = 0;
  int   t_clk, t_rel, t_arb, t_open, t_close, t_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pci_bus_bringup #(.CLK_HZ(HZ)) i_pci_bus_bringup (
    .clk(clk), .rst(rst), .start(start), .cfg_done(cfg_done),
    .bus_rst_oe(bus_rst_oe), .bus_clk_oe(bus_clk_oe), .bus_clk_en(bus_clk_en),
    .bus_rst_n(bus_rst_n), .arb_internal(arb_internal), .cfg_open(cfg_open),
    .busy(busy), .ready(ready)
  );

  function automatic logic [7:0] outs();
    return {bus_rst_oe, bus_clk_oe, bus_clk_en, bus_rst_n,
            arb_internal, cfg_open, busy, ready};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_start();
    start = 1; tick(); start = 0;
  endtask

  // Runs from idle to cfg_open and records rise times.
  task automatic run_to_open(input bit stray_done);
    pulse_start();
    check("R2 drivers on", int'(outs()), 8'b1100_0010);
    while (!bus_clk_en) tick();
    t_clk = cyc;
    check("R3 clock one cycle after drivers", int'(bus_rst_n), 0);
    while (!bus_rst_n) tick();
    t_rel = cyc;
    check("R3 reset hold cycles", t_rel - t_clk, E_HOLD);
    while (!arb_internal) tick();
    t_arb = cyc;
    check("R4 arbiter after release", t_arb - t_rel, 1);
    if (stray_done) begin
      repeat (100) tick();
      cfg_done = 1; tick(); cfg_done = 0;
    end
    while (!cfg_open) tick();
    t_open = cyc;
    check("R5 settle before config", t_open - t_arb, cyc_of(1) + cyc_of(1000));
    check("R5 settle constant", E_ARB + E_SETTLE, cyc_of(1) + cyc_of(1000));
  endtask

  initial begin
    repeat (3) tick();
    check("R1 reset outputs", int'(outs()), 0);
    rst = 0; tick();
    check("R1 after release", int'(outs()), 0);

    // Pattern 1: full run with stray cfg_done during the settle wait.
    run_to_open(1'b1);
    repeat (50) tick();
    check("R9 stray done ignored", int'(cfg_open), 1);
    check("R6 busy while open", int'(busy), 1);
    cfg_done = 1; tick(); cfg_done = 0;
    check("R6 open closes", int'(cfg_open), 0);
    t_close = cyc;
    while (!ready) tick();
    t_rdy = cyc;
    check("R6 ready delay", t_rdy - t_close, E_READY);
    check("R6 busy low when ready", int'(busy), 0);
    check("R7 ready outputs", int'(outs()), 8'b1111_1001);
    pulse_start();
    repeat (5) tick();
    check("R7 start ignored when ready", int'(outs()), 8'b1111_1001);

    // Pattern 2: abort during the reset hold.
    rst = 1; tick(); rst = 0;
    check("R8 reset from ready", int'(outs()), 0);
    pulse_start();
    repeat (100) tick();
    check("R3 still in hold", int'(outs()), 8'b1110_0010);
    rst = 1; tick();
    check("R8 reset mid sequence", int'(outs()), 0);
    rst = 0; repeat (3) tick();
    check("R8 stays idle", int'(outs()), 0);

    // Pattern 3: cfg_done held high all along.
    cfg_done = 1;
    run_to_open(1'b0);
    tick();
    check("R6 open one cycle", int'(cfg_open), 0);
    t_close = cyc;
    check("R6 open width", t_close - t_open, 1);
    while (!ready) tick();
    check("R6 ready delay held done", cyc - t_close, E_READY);
    cfg_done = 0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule